// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow four-register window onto a second, internal register bus. The host loads a data word, then writes a command word. The command word carries a target address and an operation selector, and writing it starts exactly one transfer on the internal bus. While the transfer runs, the host reads a status word until a completion flag appears. The status word also holds a two-bit result code, which tells apart a target that never answered, a clean finish, a refused request and an answer flagged as bad. Read results land in a read-back register.

On the internal bus, a transfer has two phases. In the request phase the bridge holds a request until the target either accepts it (grant) or refuses it (reject). In the response phase the bridge waits for a response strobe, which may carry an error flag. Each phase has its own watchdog of `TMO_CYCLES` clock cycles. If a phase reaches that limit with no answer, the transfer ends with result "no response".

Top module: `ibr_bridge`

## Requirements
- R1: After reset the status word, write-data, command and read-data registers all read as zero, and no bus request is raised.
- R2: A command word with selector 1 in bits [17:16] and address in bits [15:0] raises a bus request with `ib_wr`=1, that address and the write-data register as `ib_wdata`. A clean response ends it with ready (status bit 18) set and result code 1 in bits [17:16].
- R3: A command with selector 2 issues a read. On a clean response the response data is stored in the read-data register, and the result code is 1.
- R4: A reject during the request phase ends the transfer at once: request dropped, ready set, result code 2, and no response phase.
- R5: A response carrying the error flag ends the transfer with result code 3, and the read-data register keeps its old value.
- R6: If either phase sees no answer for `TMO_CYCLES` cycles, the request is dropped and the transfer ends with ready set and result code 0.
- R7: The clock edge that accepts a valid command clears ready and the result code, and sets the busy flag (status bit 19). Busy and ready are never set together.
- R8: While busy, writes to the command register and the write-data register are ignored: there is no second bus request, and both registers read back unchanged.
- R9: Selector 0 or 3 raises no bus request. On the next edge the transfer completes with ready set and result code 2.
- R10: Address, direction and write data stay stable while the request waits. Each accepted command produces exactly one request.
- R11: The host read address selects the register: 0 gives write-data, 1 gives the last accepted command, 2 gives read-data, 3 gives the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_waddr | input | 2 | Host write register select (0 data, 1 command) |
| hst_wdata | input | DW | Host write value |
| hst_raddr | input | 2 | Host read register select |
| hst_rdata | output | DW | Selected register value |
| ib_req | output | 1 | Internal bus request held during the request phase |
| ib_wr | output | 1 | Transfer direction, 1 for write |
| ib_addr | output | AW | Internal target address |
| ib_wdata | output | DW | Internal write value |
| ib_gnt | input | 1 | Target accepts the request |
| ib_rej | input | 1 | Target refuses the request |
| ib_rsp_valid | input | 1 | Response strobe |
| ib_rsp_err | input | 1 | Response error flag |
| ib_rsp_data | input | DW | Response read value |

## Verification
The assertions assume the following about the target:
- grant and reject are only meaningful while a request is raised;
- a response strobe counts only in the response phase;
- strobes last one cycle.

The bench's target model keeps to these rules. It acts only on falling edges. It waits for a raised request before granting or rejecting, and it returns at most one response strobe after each grant. Its programmed delays stay below the watchdog limit, except in the cases built to trip the watchdog. In those cases it stays silent until it sees the request fall.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } xfer_st_e;

    // operation selector values
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    // completion result codes
    localparam logic [1:0] CC_NORSP   = 2'd0;
    localparam logic [1:0] CC_OK      = 2'd1;
    localparam logic [1:0] CC_REQFAIL = 2'd2;
    localparam logic [1:0] CC_RSPERR  = 2'd3;

    // status word layout
    localparam int STS_CODE_LSB = 16;
    localparam int STS_RDY_BIT  = 18;
    localparam int STS_BUSY_BIT = 19;

    // host window selects
    localparam logic [1:0] WIN_WDATA  = 2'd0;
    localparam logic [1:0] WIN_CMD    = 2'd1;
    localparam logic [1:0] WIN_RDATA  = 2'd2;
    localparam logic [1:0] WIN_STATUS = 2'd3;

endpackage

// File: rtl/ibr_window.sv
module ibr_window
    import ibr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_we_i,
    input  logic [1:0]    hst_waddr_i,
    input  logic [DW-1:0] hst_wdata_i,
    input  logic          busy_i,
    output logic [DW-1:0] wdata_o,
    output logic [AW+1:0] cmd_o,
    output logic          launch_o,
    output logic [1:0]    launch_op_o
);

    localparam int CW = AW + 2;

    typedef struct packed {
        logic [DW-1:0] wdata;
        logic [CW-1:0] cmd;
    } win_t;

    win_t win_d, win_q;
    logic wr_data, wr_cmd;

    always_comb begin
        wr_data = hst_we_i && (hst_waddr_i == WIN_WDATA) && !busy_i;
        wr_cmd  = hst_we_i && (hst_waddr_i == WIN_CMD) && !busy_i;
        win_d   = win_q;
        if (wr_data) win_d.wdata = hst_wdata_i;
        if (wr_cmd)  win_d.cmd   = hst_wdata_i[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign wdata_o     = win_q.wdata;
    assign cmd_o       = win_q.cmd;
    assign launch_o    = wr_cmd;
    assign launch_op_o = hst_wdata_i[CW-1:AW];

    // R8: a command write while busy leaves the command register alone
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hst_we_i && hst_waddr_i == WIN_CMD) |=> $stable(cmd_o));

    // R8: a data write while busy leaves the write-data register alone
    p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hst_we_i && hst_waddr_i == WIN_WDATA) |=> $stable(wdata_o));

endmodule

// File: rtl/ibr_xfer.sv
module ibr_xfer
    import ibr_pkg::*;
#(
    parameter int DW         = 32,
    parameter int TMO_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [1:0]    op_i,
    input  logic          gnt_i,
    input  logic          rej_i,
    input  logic          rsp_valid_i,
    input  logic          rsp_err_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic          req_o,
    output logic          busy_o,
    output logic          ready_o,
    output logic [1:0]    code_o,
    output logic [DW-1:0] rdata_o
);

    localparam int CNT_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    typedef struct packed {
        xfer_st_e      st;
        logic [CNT_W-1:0] cnt;
        logic          ready;
        logic [1:0]    code;
        logic          is_rd;
        logic [DW-1:0] rdata;
    } xfer_t;

    xfer_t x_d, x_q;
    logic  op_ok;

    assign op_ok = (op_i == OP_WRITE) || (op_i == OP_READ);

    always_comb begin
        x_d = x_q;
        unique case (x_q.st)
            ST_IDLE, ST_DONE: begin
                if (launch_i) begin
                    if (op_ok) begin
                        x_d.st    = ST_REQ;
                        x_d.cnt   = '0;
                        x_d.ready = 1'b0;
                        x_d.code  = CC_NORSP;
                        x_d.is_rd = (op_i == OP_READ);
                    end else begin
                        x_d.st    = ST_DONE;
                        x_d.ready = 1'b1;
                        x_d.code  = CC_REQFAIL;
                    end
                end
            end
            ST_REQ: begin
                if (rej_i) begin
                    x_d.st    = ST_DONE;
                    x_d.ready = 1'b1;
                    x_d.code  = CC_REQFAIL;
                end else if (gnt_i) begin
                    x_d.st  = ST_RSP;
                    x_d.cnt = '0;
                end else if (x_q.cnt == CNT_LAST) begin
                    x_d.st    = ST_DONE;
                    x_d.ready = 1'b1;
                    x_d.code  = CC_NORSP;
                end else begin
                    x_d.cnt = x_q.cnt + 1'b1;
                end
            end
            ST_RSP: begin
                if (rsp_valid_i) begin
                    x_d.st    = ST_DONE;
                    x_d.ready = 1'b1;
                    if (rsp_err_i) begin
                        x_d.code = CC_RSPERR;
                    end else begin
                        x_d.code = CC_OK;
                        if (x_q.is_rd) x_d.rdata = rsp_data_i;
                    end
                end else if (x_q.cnt == CNT_LAST) begin
                    x_d.st    = ST_DONE;
                    x_d.ready = 1'b1;
                    x_d.code  = CC_NORSP;
                end else begin
                    x_d.cnt = x_q.cnt + 1'b1;
                end
            end
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign req_o   = (x_q.st == ST_REQ);
    assign busy_o  = (x_q.st == ST_REQ) || (x_q.st == ST_RSP);
    assign ready_o = x_q.ready;
    assign code_o  = x_q.code;
    assign rdata_o = x_q.rdata;

    // R7: accepting a valid command clears the result and marks busy
    p_launch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && op_ok && !busy_o) |=> (busy_o && !ready_o && code_o == CC_NORSP));

    // R7: busy and ready are exclusive
    p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ready_o);

    // R9: an unknown selector finishes at once as a refused request
    p_badop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !op_ok && !busy_o) |=> (ready_o && code_o == CC_REQFAIL && !req_o));

    // R4: a reject closes the transfer without a response phase
    p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && rej_i) |=> (ready_o && !busy_o && code_o == CC_REQFAIL));

    // R2: a clean response completes with OK
    p_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.st == ST_RSP && rsp_valid_i && !rsp_err_i) |=> (ready_o && code_o == CC_OK));

    // R3: a clean read response is captured
    p_rdcap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.st == ST_RSP && rsp_valid_i && !rsp_err_i && x_q.is_rd)
        |=> (rdata_o == $past(rsp_data_i)));

    // R5: an error response reports code 3 and keeps read data
    p_rsperr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.st == ST_RSP && rsp_valid_i && rsp_err_i)
        |=> (code_o == CC_RSPERR && $stable(rdata_o)));

    // R6: an unanswered request times out with code 0
    p_tmo_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i && !rej_i && x_q.cnt == CNT_LAST)
        |=> (ready_o && !req_o && code_o == CC_NORSP));

    // R6: the phase counter never passes the limit
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        x_q.cnt <= CNT_LAST);

endmodule

// File: rtl/ibr_rdmux.sv
module ibr_rdmux
    import ibr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic [1:0]    raddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW+1:0] cmd_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          busy_i,
    input  logic          ready_i,
    input  logic [1:0]    code_i,
    output logic [DW-1:0] word_o
);

    logic [DW-1:0] sts;

    always_comb begin
        sts = '0;
        sts[STS_CODE_LSB +: 2] = code_i;
        sts[STS_RDY_BIT]       = ready_i;
        sts[STS_BUSY_BIT]      = busy_i;
        unique case (raddr_i)
            WIN_WDATA: word_o = wdata_i;
            WIN_CMD:   word_o = DW'(cmd_i);
            WIN_RDATA: word_o = rdata_i;
            default:   word_o = sts;
        endcase
    end

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int TMO_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_we,
    input  logic [1:0]    hst_waddr,
    input  logic [DW-1:0] hst_wdata,
    input  logic [1:0]    hst_raddr,
    output logic [DW-1:0] hst_rdata,
    output logic          ib_req,
    output logic          ib_wr,
    output logic [AW-1:0] ib_addr,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_gnt,
    input  logic          ib_rej,
    input  logic          ib_rsp_valid,
    input  logic          ib_rsp_err,
    input  logic [DW-1:0] ib_rsp_data
);

    logic [DW-1:0] wdata_w, rdata_w;
    logic [AW+1:0] cmd_w;
    logic          launch_w, busy_w, ready_w;
    logic [1:0]    launch_op_w, code_w;

    ibr_window #(.AW(AW), .DW(DW)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .hst_we_i    (hst_we),
        .hst_waddr_i (hst_waddr),
        .hst_wdata_i (hst_wdata),
        .busy_i      (busy_w),
        .wdata_o     (wdata_w),
        .cmd_o       (cmd_w),
        .launch_o    (launch_w),
        .launch_op_o (launch_op_w)
    );

    ibr_xfer #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch_w),
        .op_i        (launch_op_w),
        .gnt_i       (ib_gnt),
        .rej_i       (ib_rej),
        .rsp_valid_i (ib_rsp_valid),
        .rsp_err_i   (ib_rsp_err),
        .rsp_data_i  (ib_rsp_data),
        .req_o       (ib_req),
        .busy_o      (busy_w),
        .ready_o     (ready_w),
        .code_o      (code_w),
        .rdata_o     (rdata_w)
    );

    ibr_rdmux #(.AW(AW), .DW(DW)) u_rdmux (
        .raddr_i (hst_raddr),
        .wdata_i (wdata_w),
        .cmd_i   (cmd_w),
        .rdata_i (rdata_w),
        .busy_i  (busy_w),
        .ready_i (ready_w),
        .code_i  (code_w),
        .word_o  (hst_rdata)
    );

    assign ib_addr  = cmd_w[AW-1:0];
    assign ib_wr    = (cmd_w[AW+1:AW] == OP_WRITE);
    assign ib_wdata = wdata_w;

    // R10: a waiting request keeps its address, direction and data
    p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_gnt && !ib_rej)
        |=> (!ib_req || ($stable(ib_addr) && $stable(ib_wr) && $stable(ib_wdata))));

endmodule

// File: tb/ibr_bridge_tb_top.sv
`timescale 1ns/1ps
module ibr_bridge_tb_top;
    import ibr_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TMO = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_we = 1'b0;
    logic [1:0]    hst_waddr = '0;
    logic [DW-1:0] hst_wdata = '0;
    logic [1:0]    hst_raddr;
    logic [DW-1:0] hst_rdata;
    logic          ib_req, ib_wr;
    logic [AW-1:0] ib_addr;
    logic [DW-1:0] ib_wdata;
    logic          ib_gnt = 1'b0, ib_rej = 1'b0, ib_rsp_valid = 1'b0, ib_rsp_err = 1'b0;
    logic [DW-1:0] ib_rsp_data = '0;

    always #2.5 clk = ~clk;

    ibr_bridge #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_waddr(hst_waddr),
        .hst_wdata(hst_wdata), .hst_raddr(hst_raddr), .hst_rdata(hst_rdata),
        .ib_req(ib_req), .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_gnt(ib_gnt), .ib_rej(ib_rej), .ib_rsp_valid(ib_rsp_valid),
        .ib_rsp_err(ib_rsp_err), .ib_rsp_data(ib_rsp_data)
    );

    int nchk = 0;
    int nbad = 0;

    typedef struct {
        string       tag;
        logic [1:0]  code;
        logic [31:0] rd;
    } exp_t;
    exp_t exq[$];

    logic       mon_act = 1'b0;
    logic [1:0] mon_raddr = 2'd3;
    logic [1:0] drv_raddr = 2'd0;
    assign hst_raddr = mon_act ? mon_raddr : drv_raddr;

    // target model state
    logic [31:0] smem [16];
    int  sv_gnt_dly = 0, sv_rsp_dly = 0;
    bit  sv_rej = 0, sv_no_gnt = 0, sv_no_rsp = 0, sv_err = 0;
    logic [15:0] exp_addr = '0;
    logic        exp_wr = 1'b0;
    logic [31:0] wdata_m = '0;
    logic [31:0] rd_m = '0;
    int  req_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    task automatic drv_read(input logic [1:0] a, output logic [31:0] v);
        drv_raddr = a;
        #1;
        v = hst_rdata;
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        hst_we = 1'b1; hst_waddr = a; hst_wdata = v;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic slave_cfg(input int gd, input int rdl, input bit rj, input bit ng,
                             input bit nr, input bit er);
        sv_gnt_dly = gd; sv_rsp_dly = rdl; sv_rej = rj;
        sv_no_gnt = ng; sv_no_rsp = nr; sv_err = er;
    endtask

    // driver: launch one command, optionally poke the window while busy
    task automatic issue(input string tag, input logic [1:0] op, input logic [15:0] addr,
                         input logic [1:0] ecode, input logic [31:0] erd, input bit poke);
        logic [31:0] v;
        exp_addr = addr;
        exp_wr   = (op == OP_WRITE);
        host_wr(WIN_CMD, {14'd0, op, addr});
        if (op == OP_WRITE || op == OP_READ) begin
            drv_read(WIN_STATUS, v);
            chk("R7 busy set, ready/code cleared", {28'd0, v[19:16]}, 32'h8);
        end
        if (poke) begin
            host_wr(WIN_CMD, {14'd0, OP_READ, 16'h7777});
            host_wr(WIN_WDATA, 32'hFFFF_0000);
        end
        exq.push_back('{tag, ecode, erd});
        while (exq.size() != 0) @(negedge clk);
        @(negedge clk);
        if (poke) begin
            drv_read(WIN_CMD, v);
            chk("R8 cmd kept while busy", v, {14'd0, op, addr});
            drv_read(WIN_WDATA, v);
            chk("R8 wdata kept while busy", v, wdata_m);
        end
    endtask

    // target model
    initial begin
        for (int i = 0; i < 16; i++) smem[i] = 32'h0101_0101 * i;
        forever begin
            @(negedge clk);
            if (ib_req) begin
                req_cnt++;
                chk("R10 request addr", {16'd0, ib_addr}, {16'd0, exp_addr});
                chk("R2 request dir", {31'd0, ib_wr}, {31'd0, exp_wr});
                if (exp_wr) chk("R2 request wdata", ib_wdata, wdata_m);
                if (sv_no_gnt) begin
                    while (ib_req) @(negedge clk);
                end else begin
                    repeat (sv_gnt_dly) @(negedge clk);
                    if (sv_rej) ib_rej = 1'b1; else ib_gnt = 1'b1;
                    @(negedge clk);
                    ib_rej = 1'b0; ib_gnt = 1'b0;
                    if (!sv_rej && !sv_no_rsp) begin
                        repeat (sv_rsp_dly) @(negedge clk);
                        ib_rsp_valid = 1'b1;
                        ib_rsp_err   = sv_err;
                        if (sv_err)     ib_rsp_data = 32'hBAD0_0BAD;
                        else if (ib_wr) ib_rsp_data = 32'h0;
                        else            ib_rsp_data = smem[ib_addr[3:0]];
                        if (!sv_err && ib_wr) smem[ib_addr[3:0]] = ib_wdata;
                        @(negedge clk);
                        ib_rsp_valid = 1'b0; ib_rsp_err = 1'b0;
                    end
                end
            end
        end
    end

    // monitor: polls for completion and scores against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (exq.size() != 0) begin
                bit done;
                done = 0;
                mon_act = 1'b1;
                for (int i = 0; i < 3 * TMO && !done; i++) begin
                    mon_raddr = WIN_STATUS;
                    #1;
                    if (hst_rdata[18]) done = 1;
                    else @(negedge clk);
                end
                if (!done) begin
                    nchk++; nbad++;
                    $display("FAIL %s no completion actual=0 expected=1", exq[0].tag);
                end else begin
                    chk({exq[0].tag, " code"}, {30'd0, hst_rdata[17:16]}, {30'd0, exq[0].code});
                    chk({exq[0].tag, " busy off"}, {31'd0, hst_rdata[19]}, 32'd0);
                    mon_raddr = WIN_RDATA;
                    #1;
                    chk({exq[0].tag, " rdata"}, hst_rdata, exq[0].rd);
                end
                void'(exq.pop_front());
                mon_act = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        nchk++; nbad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        logic [31:0] v;
        int base;
        repeat (4) @(negedge clk);
        // R1: reset state
        drv_read(WIN_STATUS, v); chk("R1 status", v, 32'd0);
        drv_read(WIN_WDATA, v);  chk("R1 wdata", v, 32'd0);
        drv_read(WIN_CMD, v);    chk("R1 cmd", v, 32'd0);
        drv_read(WIN_RDATA, v);  chk("R1 rdata", v, 32'd0);
        chk("R1 no request", {31'd0, ib_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no request after release", {31'd0, ib_req}, 32'd0);

        // R11: window readback
        wdata_m = 32'h1234_5678;
        host_wr(WIN_WDATA, wdata_m);
        drv_read(WIN_WDATA, v); chk("R11 wdata readback", v, wdata_m);

        // R2: write, immediate answers
        slave_cfg(0, 0, 0, 0, 0, 0);
        issue("R2 write", OP_WRITE, 16'h0005, CC_OK, rd_m, 0);
        drv_read(WIN_CMD, v); chk("R11 cmd readback", v, {14'd0, OP_WRITE, 16'h0005});

        // R3: read back the written word
        rd_m = wdata_m;
        issue("R3 read", OP_READ, 16'h0005, CC_OK, rd_m, 0);
        drv_read(WIN_RDATA, v); chk("R11 rdata readback", v, rd_m);

        // R3: read with delays, untouched location; high address bits ignored by model
        slave_cfg(3, 4, 0, 0, 0, 0);
        rd_m = 32'h0909_0909;
        issue("R3 delayed read", OP_READ, 16'hAB09, CC_OK, rd_m, 0);

        // R2: delayed write to another address, then read it
        wdata_m = 32'hCAFE_0042;
        host_wr(WIN_WDATA, wdata_m);
        slave_cfg(2, 1, 0, 0, 0, 0);
        issue("R2 delayed write", OP_WRITE, 16'h0C03, CC_OK, rd_m, 0);
        rd_m = wdata_m;
        slave_cfg(0, 2, 0, 0, 0, 0);
        issue("R3 read after write", OP_READ, 16'h0C03, CC_OK, rd_m, 0);

        // R4: rejected request
        slave_cfg(1, 0, 1, 0, 0, 0);
        issue("R4 reject", OP_READ, 16'h0001, CC_REQFAIL, rd_m, 0);
        chk("R4 request dropped", {31'd0, ib_req}, 32'd0);

        // R5: error response keeps rdata
        slave_cfg(0, 1, 0, 0, 0, 1);
        issue("R5 rsp error", OP_READ, 16'h0002, CC_RSPERR, rd_m, 0);

        // R6: no grant, then no response
        slave_cfg(0, 0, 0, 1, 0, 0);
        issue("R6 grant timeout", OP_READ, 16'h0004, CC_NORSP, rd_m, 0);
        chk("R6 request dropped", {31'd0, ib_req}, 32'd0);
        slave_cfg(0, 0, 0, 0, 1, 0);
        issue("R6 response timeout", OP_WRITE, 16'h0006, CC_NORSP, rd_m, 0);

        // R8: pokes while busy are ignored, one request only
        base = req_cnt;
        slave_cfg(8, 2, 0, 0, 0, 0);
        rd_m = smem[1];
        issue("R8 busy poke", OP_READ, 16'h0001, CC_OK, rd_m, 1);
        chk("R8 single request", req_cnt - base, 32'd1);

        // R9: invalid selectors
        base = req_cnt;
        slave_cfg(0, 0, 0, 0, 0, 0);
        issue("R9 selector 0", 2'd0, 16'h0003, CC_REQFAIL, rd_m, 0);
        issue("R9 selector 3", 2'd3, 16'h0003, CC_REQFAIL, rd_m, 0);
        chk("R9 no request", req_cnt - base, 32'd0);

        // R7: a fresh valid command after a failure clears the old result
        rd_m = smem[3];
        issue("R7 clear after fail", OP_READ, 16'h0003, CC_OK, rd_m, 0);

        repeat (4) @(negedge clk);
        report();
    end

endmodule